// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a processor's two-part virtual address, a segment number and a word offset within that segment, into an absolute word address. It reads the segment's descriptor word from a table in memory whose start address is held on a base-address input. The descriptor is indexed by segment number. A descriptor either gives the base of a contiguous unpaged segment, or points at a page table whose entries hold page frame numbers. Either kind of table word may carry an absent tag. A descriptor also holds permission flags and a length, and these are checked against each request. Any failure returns a fault code along with the segment and page involved. In that case no address is produced.

Successful paged translations are kept in a small fully associative cache. A later request to the same segment and page then completes in one cycle with no table reads. A flush input clears that cache. A bypass input makes the block pass the virtual address through untranslated. The processor side is a single-request interface: a ready output, a request strobe, and a one-cycle response pulse. The memory side is a read port that issues one-cycle read strobes and accepts data with a valid strobe after any latency.

Top module: `sxlat_top`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_rd are 0.
- R2: When bypass is 1 at acceptance, the response follows in the next cycle with fault 0, no memory read, no checks, and rsp_addr equal to the low PA_W bits of {seg, offset}, zero-extended if narrower.
- R3: A miss reads the descriptor at dbr + seg. Descriptor layout: bit 0 present, bit 1 unpaged, bit 2 read, bit 3 write, bit 4 execute, bits [13:5] length in 1024-word pages, bits [37:14] base address. If the present bit is 0, the result is fault code 1 (segment) after that single read.
- R4: If the page index (offset >> 10) is at least the length field, the result is fault code 2 (bounds).
- R5: Access kinds are encoded 0 read, 1 write, 2 execute. Kind 3 never passes the check. If the flag for the kind is missing, the result is fault code 3 (access).
- R6: An unpaged segment gives rsp_addr = base + offset after exactly one read.
- R7: A paged segment takes a second read at base + page index. The page word has bit 0 present and bits [14:1] frame. rsp_addr = {frame, offset[9:0]}.
- R8: A page word with bit 0 clear gives fault code 4 (page).
- R9: Fault priority is segment, then bounds, then access, then page. Any fault response has rsp_addr 0. Every response echoes the request's segment and page index.
- R10: A successful paged translation is cached. A later request to the same segment and page responds in the cycle after acceptance with no reads. The cached permission flags are still checked, giving fault code 3 on a mismatch.
- R11: The cache has 16 entries. Fills go round-robin, so the 17th fill since reset or a flush replaces the oldest entry.
- R12: flush invalidates every entry and restarts the fill order. A request accepted in the same cycle as flush is a miss.
- R13: Unpaged and faulted translations are not cached, so repeating them repeats the table reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | Pass addresses through untranslated |
| flush | input | 1 | Invalidate the translation cache |
| dbr | input | PA_W | Descriptor table base address |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and able to accept |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Word offset in segment |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | PA_W | Absolute address, 0 on fault |
| rsp_fault | output | 3 | Fault code, 0 when none |
| rsp_seg | output | SEG_W | Segment of the answered request |
| rsp_page | output | OFF_W-PAGE_W | Page index of the answered request |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | PA_W | Table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 5+LEN_W+PA_W | Table word |

## Verification
The bench runs several kinds of request through the translator:
- Requests to an absent segment, to an unpaged segment and to a paged segment show that the descriptor's type bits steer the walk. The read count and the response cycle show whether one table read was made or two.
- Descriptors built so that several faults apply at once show that the fault priority is fixed.
- Repeating a paged request with a different access kind shows that a cache hit still checks permissions.
- A sweep across seventeen pages, followed by revisits of the first pages, shows round-robin replacement.
- Bypass requests and flush-tagged requests show that both skip or defeat the cache.

// File: rtl/sxlat_pkg.sv
package sxlat_pkg;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_SEG    = 3'd1,
      FLT_BOUND  = 3'd2,
      FLT_ACCESS = 3'd3,
      FLT_PAGE   = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DESC = 2'd1,
      ST_PTW  = 2'd2
   } walk_st_e;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } perm_t;

   // Access kind: 0 read, 1 write, 2 execute, 3 never allowed
   function automatic logic perm_ok(perm_t p, logic [1:0] kind);
      case (kind)
         2'd0:    return p.r;
         2'd1:    return p.w;
         2'd2:    return p.x;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/sxlat_desc_check.sv
module sxlat_desc_check
   import sxlat_pkg::*;
#(
   parameter int OFF_W  = 18,
   parameter int PAGE_W = 10,
   parameter int PA_W   = 24,
   localparam int PIDX_W = OFF_W - PAGE_W,
   localparam int LEN_W  = PIDX_W + 1,
   localparam int DW     = 5 + LEN_W + PA_W
) (
   input  logic [DW-1:0]     desc,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        kind,
   output logic [2:0]        fault,
   output logic              unpaged,
   output perm_t             perm,
   output logic [PA_W-1:0]   base,
   output logic [PIDX_W-1:0] page
);

   logic             present;
   logic [LEN_W-1:0] len;

   always_comb begin
      present = desc[0];
      unpaged = desc[1];
      perm    = '{r: desc[2], w: desc[3], x: desc[4]};
      len     = desc[5 +: LEN_W];
      base    = desc[5 + LEN_W +: PA_W];
      page    = off[OFF_W-1:PAGE_W];
      if (!present)
         fault = FLT_SEG;
      else if ({1'b0, page} >= len)
         fault = FLT_BOUND;
      else if (!perm_ok(perm, kind))
         fault = FLT_ACCESS;
      else
         fault = FLT_NONE;
   end

endmodule

// File: rtl/sxlat_tlb.sv
module sxlat_tlb #(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 20,
   parameter int PAY_W   = 17,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [KEY_W-1:0] lk_key,
   output logic             lk_hit,
   output logic [PAY_W-1:0] lk_pay,
   input  logic             fill_en,
   input  logic [KEY_W-1:0] fill_key,
   input  logic [PAY_W-1:0] fill_pay
);

   logic [ENTRIES-1:0] match;
   logic [PAY_W-1:0]   masked [ENTRIES];
   logic [IDX_W-1:0]   victim;

   initial begin : elab_chk
      assert (ENTRIES >= 1) else $error("sxlat_tlb: ENTRIES must be at least 1");
   end

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         logic             v;
         logic [KEY_W-1:0] k;
         logic [PAY_W-1:0] p;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v <= 1'b0;
               k <= '0;
               p <= '0;
            end else if (flush) begin
               v <= 1'b0;
            end else if (fill_en && victim == IDX_W'(i)) begin
               v <= 1'b1;
               k <= fill_key;
               p <= fill_pay;
            end
         end

         assign match[i]  = v && (k == lk_key);
         assign masked[i] = match[i] ? p : '0;
      end
   endgenerate

   always_comb begin
      lk_hit = |match;
      lk_pay = '0;
      for (int i = 0; i < ENTRIES; i++)
         lk_pay = lk_pay | masked[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         victim <= '0;
      else if (flush)
         victim <= '0;
      else if (fill_en)
         victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
   end

endmodule

// File: rtl/sxlat_top.sv
module sxlat_top
   import sxlat_pkg::*;
#(
   parameter int SEG_W  = 12,
   parameter int OFF_W  = 18,
   parameter int PAGE_W = 10,
   parameter int PA_W   = 24,
   parameter int TLB_N  = 16,
   localparam int PIDX_W = OFF_W - PAGE_W,
   localparam int LEN_W  = PIDX_W + 1,
   localparam int DW     = 5 + LEN_W + PA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass,
   input  logic              flush,
   input  logic [PA_W-1:0]   dbr,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_kind,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_addr,
   output logic [2:0]        rsp_fault,
   output logic [SEG_W-1:0]  rsp_seg,
   output logic [PIDX_W-1:0] rsp_page,
   output logic              mem_rd,
   output logic [PA_W-1:0]   mem_addr,
   input  logic              mem_rvalid,
   input  logic [DW-1:0]     mem_rdata
);

   localparam int FRAME_W = PA_W - PAGE_W;
   localparam int PAY_W   = FRAME_W + 3;
   localparam int KEY_W   = SEG_W + PIDX_W;
   localparam int VA_W    = SEG_W + OFF_W;

   initial begin : elab_chk
      assert (OFF_W > PAGE_W) else $error("sxlat_top: OFF_W must exceed PAGE_W");
      assert (PA_W >= OFF_W)  else $error("sxlat_top: PA_W must cover OFF_W");
      assert (PA_W > PAGE_W)  else $error("sxlat_top: PA_W must exceed PAGE_W");
      assert (SEG_W >= 1)     else $error("sxlat_top: SEG_W must be positive");
      assert (TLB_N >= 1)     else $error("sxlat_top: TLB_N must be positive");
   end

   walk_st_e           st;
   logic [SEG_W-1:0]   c_seg;
   logic [OFF_W-1:0]   c_off;
   logic [1:0]         c_kind;
   perm_t              c_perm;

   logic               tlb_hit, hit_use;
   logic [PAY_W-1:0]   tlb_pay;
   perm_t              hit_perm;
   logic               fill_en;
   logic [PIDX_W-1:0]  req_page, c_page;

   logic [2:0]         dc_fault;
   logic               dc_unpaged;
   perm_t              dc_perm;
   logic [PA_W-1:0]    dc_base;
   logic [PIDX_W-1:0]  dc_page;

   logic               ptw_present;
   logic [FRAME_W-1:0] ptw_frame;
   logic [PA_W-1:0]    byp_addr;
   logic [VA_W-1:0]    va;

   assign req_ready   = (st == ST_IDLE);
   assign req_page    = req_off[OFF_W-1:PAGE_W];
   assign c_page      = c_off[OFF_W-1:PAGE_W];
   assign hit_use     = tlb_hit && !flush;
   assign hit_perm    = perm_t'(tlb_pay[2:0]);
   assign ptw_present = mem_rdata[0];
   assign ptw_frame   = mem_rdata[1 +: FRAME_W];
   assign fill_en     = (st == ST_PTW) && mem_rvalid && ptw_present;
   assign va          = {req_seg, req_off};

   generate
      if (VA_W >= PA_W) begin : g_byp_trunc
         assign byp_addr = va[PA_W-1:0];
      end else begin : g_byp_ext
         assign byp_addr = {{(PA_W - VA_W){1'b0}}, va};
      end
   endgenerate

   sxlat_tlb #(
      .ENTRIES (TLB_N),
      .KEY_W   (KEY_W),
      .PAY_W   (PAY_W)
   ) u_tlb (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .lk_key   ({req_seg, req_page}),
      .lk_hit   (tlb_hit),
      .lk_pay   (tlb_pay),
      .fill_en  (fill_en),
      .fill_key ({c_seg, c_page}),
      .fill_pay ({ptw_frame, c_perm})
   );

   sxlat_desc_check #(
      .OFF_W  (OFF_W),
      .PAGE_W (PAGE_W),
      .PA_W   (PA_W)
   ) u_dchk (
      .desc    (mem_rdata),
      .off     (c_off),
      .kind    (c_kind),
      .fault   (dc_fault),
      .unpaged (dc_unpaged),
      .perm    (dc_perm),
      .base    (dc_base),
      .page    (dc_page)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         c_seg     <= '0;
         c_off     <= '0;
         c_kind    <= '0;
         c_perm    <= '0;
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_fault <= FLT_NONE;
         rsp_seg   <= '0;
         rsp_page  <= '0;
         mem_rd    <= 1'b0;
         mem_addr  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         mem_rd    <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  c_seg  <= req_seg;
                  c_off  <= req_off;
                  c_kind <= req_kind;
                  if (bypass) begin
                     rsp_valid <= 1'b1;
                     rsp_addr  <= byp_addr;
                     rsp_fault <= FLT_NONE;
                     rsp_seg   <= req_seg;
                     rsp_page  <= req_page;
                  end else if (hit_use) begin
                     rsp_valid <= 1'b1;
                     rsp_seg   <= req_seg;
                     rsp_page  <= req_page;
                     if (perm_ok(hit_perm, req_kind)) begin
                        rsp_addr  <= {tlb_pay[PAY_W-1:3], req_off[PAGE_W-1:0]};
                        rsp_fault <= FLT_NONE;
                     end else begin
                        rsp_addr  <= '0;
                        rsp_fault <= FLT_ACCESS;
                     end
                  end else begin
                     mem_rd   <= 1'b1;
                     mem_addr <= dbr + PA_W'(req_seg);
                     st       <= ST_DESC;
                  end
               end
            end
            ST_DESC: begin
               if (mem_rvalid) begin
                  if (dc_fault != FLT_NONE) begin
                     rsp_valid <= 1'b1;
                     rsp_addr  <= '0;
                     rsp_fault <= dc_fault;
                     rsp_seg   <= c_seg;
                     rsp_page  <= c_page;
                     st        <= ST_IDLE;
                  end else if (dc_unpaged) begin
                     rsp_valid <= 1'b1;
                     rsp_addr  <= dc_base + PA_W'(c_off);
                     rsp_fault <= FLT_NONE;
                     rsp_seg   <= c_seg;
                     rsp_page  <= c_page;
                     st        <= ST_IDLE;
                  end else begin
                     mem_rd   <= 1'b1;
                     mem_addr <= dc_base + PA_W'(dc_page);
                     c_perm   <= dc_perm;
                     st       <= ST_PTW;
                  end
               end
            end
            ST_PTW: begin
               if (mem_rvalid) begin
                  rsp_valid <= 1'b1;
                  rsp_seg   <= c_seg;
                  rsp_page  <= c_page;
                  st        <= ST_IDLE;
                  if (ptw_present) begin
                     rsp_addr  <= {ptw_frame, c_off[PAGE_W-1:0]};
                     rsp_fault <= FLT_NONE;
                  end else begin
                     rsp_addr  <= '0;
                     rsp_fault <= FLT_PAGE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sxlat_checker.sv
module sxlat_checker #(
   parameter int PA_W = 24
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bypass,
   input logic            flush,
   input logic            req_valid,
   input logic            req_ready,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_addr,
   input logic [2:0]      rsp_fault,
   input logic            mem_rd
);

   // R2: bypass answers next cycle, clean, without a table read
   assert_bypass_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && bypass) |=> (rsp_valid && rsp_fault == 3'd0 && !mem_rd));

   // R3: while a table read is outstanding the block is busy
   assert_busy_during_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !req_ready);

   // R9: a faulted response carries no address
   assert_fault_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 3'd0) |-> (rsp_addr == '0));

   // R9: only defined fault codes appear
   assert_fault_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault <= 3'd4));

   // R12: a request taken together with flush goes to the tables
   assert_flush_forces_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !bypass && flush) |=> (mem_rd && !rsp_valid));

endmodule

bind sxlat_top sxlat_checker #(.PA_W(PA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bypass    (bypass),
   .flush     (flush),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_addr  (rsp_addr),
   .rsp_fault (rsp_fault),
   .mem_rd    (mem_rd)
);

// File: tb/sxlat_top_test.sv
`timescale 1ns/1ps
module sxlat_top_test;

   localparam int SEG_W   = 12;
   localparam int OFF_W   = 18;
   localparam int PAGE_W  = 10;
   localparam int PA_W    = 24;
   localparam int PIDX_W  = 8;
   localparam int LEN_W   = 9;
   localparam int DW      = 38;
   localparam int FRAME_W = 14;
   localparam int NENT    = 16;
   localparam int AMASK   = 'hFFFFFF;

   logic              clk, rst_n, bypass, flush;
   logic [PA_W-1:0]   dbr;
   logic              req_valid, req_ready;
   logic [SEG_W-1:0]  req_seg;
   logic [OFF_W-1:0]  req_off;
   logic [1:0]        req_kind;
   logic              rsp_valid;
   logic [PA_W-1:0]   rsp_addr;
   logic [2:0]        rsp_fault;
   logic [SEG_W-1:0]  rsp_seg;
   logic [PIDX_W-1:0] rsp_page;
   logic              mem_rd;
   logic [PA_W-1:0]   mem_addr;
   logic              mem_rvalid;
   logic [DW-1:0]     mem_rdata;

   sxlat_top uut (.*);

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int rd_count = 0;
   bit finished = 0;

   // table memory, answers each read three edges later
   logic [DW-1:0] mem [int];
   int            pend = 0;
   logic [PA_W-1:0] pend_addr;

   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (pend > 0) begin
         pend = pend - 1;
         if (pend == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem.exists(int'(pend_addr)) ? mem[int'(pend_addr)] : '0;
         end
      end
      if (mem_rd) begin
         pend      = 2;
         pend_addr = mem_addr;
         rd_count  = rd_count + 1;
      end
   end

   // reference cache model
   bit tv [NENT];
   int tseg [NENT];
   int tpg [NENT];
   int tfr [NENT];
   bit tr [NENT], tw [NENT], tx [NENT];
   int tptr = 0;

   function automatic logic [DW-1:0] mk_desc(bit pres, bit unp, bit r, bit w, bit x, int len, int base);
      return {PA_W'(base), LEN_W'(len), x, w, r, unp, pres};
   endfunction

   function automatic logic [DW-1:0] mk_ptw(bit pres, int frame);
      return DW'({FRAME_W'(frame), pres});
   endfunction

   function automatic bit kind_ok(bit r, bit w, bit x, int kind);
      if (kind == 0) return r;
      if (kind == 1) return w;
      if (kind == 2) return x;
      return 1'b0;
   endfunction

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic do_req(int seg, int off, int kind, bit byp, bit fl, string rq);
      int e_addr, e_fault, e_reads, lat, r0, page, hit_i;
      logic [DW-1:0] d, p;
      bit got;
      page = off >> PAGE_W;
      e_addr = 0; e_fault = 0; e_reads = 0;
      if (byp) begin
         e_addr = ((seg << OFF_W) | off) & AMASK;
      end else begin
         if (fl) begin
            for (int i = 0; i < NENT; i++) tv[i] = 0;
            tptr = 0;
         end
         hit_i = -1;
         for (int i = 0; i < NENT; i++)
            if (tv[i] && tseg[i] == seg && tpg[i] == page) hit_i = i;
         if (hit_i >= 0) begin
            if (kind_ok(tr[hit_i], tw[hit_i], tx[hit_i], kind))
               e_addr = (tfr[hit_i] << PAGE_W) | (off & 'h3FF);
            else
               e_fault = 3;
         end else begin
            e_reads = 1;
            d = mem.exists((int'(dbr) + seg) & AMASK) ? mem[(int'(dbr) + seg) & AMASK] : '0;
            if (!d[0]) e_fault = 1;
            else if (page >= int'(d[13:5])) e_fault = 2;
            else if (!kind_ok(d[2], d[3], d[4], kind)) e_fault = 3;
            else if (d[1]) e_addr = (int'(d[37:14]) + off) & AMASK;
            else begin
               e_reads = 2;
               p = mem.exists((int'(d[37:14]) + page) & AMASK) ? mem[(int'(d[37:14]) + page) & AMASK] : '0;
               if (!p[0]) e_fault = 4;
               else begin
                  e_addr = (int'(p[14:1]) << PAGE_W) | (off & 'h3FF);
                  tv[tptr] = 1; tseg[tptr] = seg; tpg[tptr] = page; tfr[tptr] = int'(p[14:1]);
                  tr[tptr] = d[2]; tw[tptr] = d[3]; tx[tptr] = d[4];
                  tptr = (tptr + 1) % NENT;
               end
            end
         end
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off);
      req_kind = 2'(kind); bypass = byp; flush = fl;
      r0 = rd_count; lat = 0; got = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         lat++;
         if (lat == 1) begin req_valid = 1'b0; bypass = 1'b0; flush = 1'b0; end
         if (rsp_valid) begin got = 1; break; end
      end
      chk(got, rq, "response seen", longint'(got), 1);
      chk(int'(rsp_fault) == e_fault, rq, "fault code", rsp_fault, e_fault);
      chk(int'(rsp_addr) == e_addr, rq, "address", rsp_addr, e_addr);
      chk(int'(rsp_seg) == (seg & 'hFFF) && int'(rsp_page) == (page & 'hFF), rq, "seg/page echo",
          {rsp_seg, rsp_page}, ((seg & 'hFFF) << 8) | (page & 'hFF));
      chk(rd_count - r0 == e_reads, rq, "table reads", rd_count - r0, e_reads);
      chk(lat == 1 + 3 * e_reads, rq, "latency", lat, 1 + 3 * e_reads);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin : stim
      rst_n = 1'b0; bypass = 1'b0; flush = 1'b0; dbr = 24'h001000;
      req_valid = 1'b0; req_seg = '0; req_off = '0; req_kind = '0;
      mem_rvalid = 1'b0; mem_rdata = '0;
      for (int i = 0; i < NENT; i++) tv[i] = 0;

      mem['h1001] = mk_desc(1, 1, 1, 0, 1, 4, 'h20000);
      mem['h1002] = mk_desc(1, 0, 1, 1, 0, 32, 'h3000);
      for (int pg = 0; pg < 20; pg++) mem['h3000 + pg] = mk_ptw(1, 'h100 + pg);
      mem['h1003] = mk_desc(0, 0, 1, 1, 1, 8, 'h5000);
      mem['h1004] = mk_desc(1, 0, 1, 0, 0, 2, 'h6000);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_rd, "R1", "reset outputs",
          {req_ready, rsp_valid, mem_rd}, 3'b100);

      do_req(0, 'h10, 0, 0, 0, "R3");                 // absent segment
      do_req(1, 'h123, 0, 0, 0, "R6");                // unpaged read
      do_req(1, 'hFFF, 2, 0, 0, "R6");                // unpaged execute, last word
      do_req(1, 'h123, 1, 0, 0, "R5");                // write not allowed
      do_req(1, 'h10, 3, 0, 0, "R5");                 // reserved kind
      do_req(1, 'h1000, 0, 0, 0, "R4");               // page 4 of a 4-page segment
      do_req(2, (5 << 10) | 'h3A, 0, 0, 0, "R7");     // paged walk
      do_req(2, (5 << 10) | 'h155, 1, 0, 0, "R10");   // cached, write allowed
      do_req(2, (5 << 10) | 'h3A, 2, 0, 0, "R10");    // cached, execute refused
      do_req(2, 20 << 10, 0, 0, 0, "R8");             // absent page
      do_req(2, 20 << 10, 0, 0, 0, "R13");            // faulted walk repeated
      do_req(1, 'h123, 0, 0, 0, "R13");               // unpaged repeated
      do_req(3, 'h3FFFF, 3, 0, 0, "R9");              // segment beats others
      do_req(4, 5 << 10, 1, 0, 0, "R9");              // bounds beats access
      do_req(4, 0, 1, 0, 0, "R9");                    // access beats page
      do_req(4, 0, 0, 0, 0, "R9");                    // page fault last
      do_req(2, (5 << 10) | 'h3A, 0, 1, 0, "R2");     // bypass
      do_req('hFFF, 'h3FFFF, 1, 1, 0, "R2");          // bypass of absent segment
      for (int pg = 0; pg <= 16; pg++)
         do_req(2, (pg << 10) | pg, 0, 0, 0, "R11");
      do_req(2, 5 << 10, 0, 0, 0, "R11");             // oldest was replaced
      do_req(2, 1 << 10, 1, 0, 0, "R11");
      do_req(2, 0, 0, 0, 0, "R11");
      do_req(2, 7 << 10, 0, 0, 0, "R10");
      do_req(2, 6 << 10, 0, 0, 1, "R12");             // flush with request
      do_req(2, 7 << 10, 0, 0, 0, "R12");             // flushed entry gone
      do_req(2, 6 << 10, 1, 0, 0, "R12");             // refilled after flush

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule